// File: doc/BRIEF.md
# Wear-Balanced Gray Event Counter Writer

This block keeps an event counter whose persistent copy lives in byte-wide non-volatile memory. Inside one byte pair the count is held as a 16-bit reflected Gray codeword with its bits rotated one place to the right. Consecutive counts therefore differ in one stored bit, so every increment costs a single byte write. The rotation moves the fastest-toggling Gray bit into the high byte, which spreads the writes almost evenly over the two bytes of the pair. When a pair has gone through all 65536 values, counting moves on to the next pair two addresses up. This gives extra wear levelling over a parameterised number of pairs.

Each write goes out as a byte address and a data byte on a request/acknowledge handshake. A power-fail warning input stops new writes from starting, but a write already in flight still completes. One increment that cannot start at once is held as pending. A further increment in that window sets a sticky overflow flag. After reset, a restore port reloads the pair index and the stored codeword read back from memory. The block decodes that word to rebuild its binary count. Once the last pair is exhausted, the counter freezes and reports that it is worn out.

Top module: `wear_gray_counter`

## Requirements
- R1: The written data byte is the matching byte of the stored word S for the new in-pair binary count b. Here g = b ^ (b >> 1), S[15] = g[0] and S[14:0] = g[15:1].
- R2: Each started increment issues exactly one byte write, to the byte of the pair whose stored bits changed. The address is BASE_ADDR + 2*pair + 0 for the low byte (S[7:0]) and + 1 for the high byte (S[15:8]).
- R3: Over 65536 consecutive increments starting from count 0 of a pair, the low-byte address (offset 0) is written 0x7F80 times and the high-byte address (offset 1) 0x8080 times.
- R4: An increment from in-pair count 65535 moves to count 0 of the next pair. It writes 0x00 to the high byte of that new pair.
- R5: `count_out` equals pair*65536 + the in-pair binary count. It rises by exactly one with each started write.
- R6: While `pwr_warn` is high, no write starts, and a blocked increment is kept as pending. A write already in flight still completes. The pending increment starts once `pwr_warn` falls.
- R7: `wr_req` stays high, with `wr_addr` and `wr_data` stable, until `wr_ack` is sampled high. It falls on the next cycle.
- R8: One increment that arrives while it cannot start is held and issued later. An increment that arrives while one is already held sets `overflow`, which stays high until a restore.
- R9: A `restore_en` cycle loads the pair index (clamped to NUM_PAIRS-1) and the stored word, decoded back to binary. It clears the pending increment, `overflow` and `worn_out`.
- R10: An increment at count 65535 of the last pair issues no write and sets `worn_out`. The count then holds, and later increments are ignored.
- R11: After reset, `wr_req`, `overflow` and `worn_out` are 0 and `count_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc | input | 1 | One-cycle increment event |
| pwr_warn | input | 1 | Power-fail warning; blocks new writes |
| restore_en | input | 1 | Load pair index and stored word |
| restore_pair | input | PAIR_W | Pair index to restore |
| restore_word | input | 16 | Stored (rotated Gray) word to restore |
| wr_req | output | 1 | Byte write request |
| wr_addr | output | ADDR_W | Byte address of the write |
| wr_data | output | 8 | Byte value to write |
| wr_ack | input | 1 | Write acknowledge |
| count_out | output | PAIR_W+16 | Total count in binary |
| overflow | output | 1 | Sticky lost-increment flag |
| worn_out | output | 1 | All pairs exhausted |

## Verification
A wrong in-pair count or wrong rotation shows up on the very next write. Either the data byte disagrees with the rotated Gray value of the incremented count, or the write goes to the other byte of the pair. A bad pair index shows up as a wrong address on that same write, and in the upper bits of `count_out` in the same cycle. A skewed or missing toggle that never corrupts a single write only appears in the per-byte write totals over a full 65536-step pass. For that reason a whole pass is counted and checked against the wear figures, with every write compared to an independent model along the way.

// File: rtl/wgc_pkg.sv
package wgc_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  // binary count -> stored word (reflected Gray, rotated right by one)
  function automatic logic [WORD_W-1:0] to_stored(input logic [WORD_W-1:0] b);
    logic [WORD_W-1:0] g;
    g = b ^ (b >> 1);
    return {g[0], g[WORD_W-1:1]};
  endfunction
endpackage

// File: rtl/wgc_rst_sync.sv
module wgc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/wgc_gray_decode.sv
module wgc_gray_decode
  import wgc_pkg::*;
(
  input  logic [WORD_W-1:0] stored_i,
  output logic [WORD_W-1:0] bin_o
);
  logic [WORD_W-1:0] gray;

  // undo the rotation: stored bit 15 is Gray bit 0
  assign gray = {stored_i[WORD_W-2:0], stored_i[WORD_W-1]};

  // each binary bit is the parity of the Gray bits at and above it
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign bin_o[i] = ^gray[WORD_W-1:i];
  end
endmodule

// File: rtl/wgc_step.sv
module wgc_step
  import wgc_pkg::*;
#(
  parameter int NUM_PAIRS = 153,
  parameter int PAIR_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 0
) (
  input  logic [PAIR_W-1:0] pair_i,
  input  logic [WORD_W-1:0] bin_i,
  output logic              at_limit_o,
  output logic [PAIR_W-1:0] nxt_pair_o,
  output logic [WORD_W-1:0] nxt_bin_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(NUM_PAIRS - 1);

  logic              wrap;
  logic              hi_sel;
  logic [WORD_W-1:0] old_s;
  logic [WORD_W-1:0] new_s;

  always_comb begin
    wrap       = &bin_i;
    at_limit_o = wrap && (pair_i == LAST_PAIR);
    nxt_bin_o  = bin_i + WORD_W'(1);
    nxt_pair_o = wrap ? pair_i + PAIR_W'(1) : pair_i;
    old_s      = to_stored(bin_i);
    new_s      = to_stored(nxt_bin_o);
    // the single changed bit decides the byte; at wrap it is stored bit 14
    hi_sel     = (old_s[WORD_W-1:BYTE_W] != new_s[WORD_W-1:BYTE_W]);
    addr_o     = ADDR_W'(BASE_ADDR) + (ADDR_W'(nxt_pair_o) << 1) + ADDR_W'(hi_sel);
    data_o     = hi_sel ? new_s[WORD_W-1:BYTE_W] : new_s[BYTE_W-1:0];
  end
endmodule

// File: rtl/wgc_req_track.sv
module wgc_req_track (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic fire_i,
  input  logic clear_i,
  input  logic worn_i,
  output logic pending_o,
  output logic overflow_o
);
  logic pend_d;
  logic ovf_d;

  always_comb begin
    pend_d = pending_o;
    ovf_d  = overflow_o;
    if (clear_i || worn_i) begin
      pend_d = 1'b0;
      if (clear_i) ovf_d = 1'b0;
    end else if (fire_i) begin
      // one request consumed; a second one present stays held
      pend_d = inc_i && pending_o;
    end else begin
      pend_d = pending_o || inc_i;
      if (inc_i && pending_o) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_o  <= 1'b0;
      overflow_o <= 1'b0;
    end else begin
      pending_o  <= pend_d;
      overflow_o <= ovf_d;
    end
  end
endmodule

// File: rtl/wear_gray_counter.sv
module wear_gray_counter
  import wgc_pkg::*;
#(
  parameter  int NUM_PAIRS = 153,
  parameter  int ADDR_W    = 16,
  parameter  int BASE_ADDR = 0,
  localparam int PAIR_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
  localparam int CNT_W     = PAIR_W + 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              pwr_warn,
  input  logic              restore_en,
  input  logic [PAIR_W-1:0] restore_pair,
  input  logic [15:0]       restore_word,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  input  logic              wr_ack,
  output logic [CNT_W-1:0]  count_out,
  output logic              overflow,
  output logic              worn_out
);
  localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(NUM_PAIRS - 1);

  logic              rst_n_s;
  logic [PAIR_W-1:0] pair_q, pair_d;
  logic [WORD_W-1:0] bin_q, bin_d;
  logic              worn_q, worn_d;
  logic              req_q, req_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] data_q, data_d;

  logic              inc_eff, pending, fire;
  logic              at_limit;
  logic [PAIR_W-1:0] nxt_pair, rest_pair;
  logic [WORD_W-1:0] nxt_bin, rest_bin;
  logic [ADDR_W-1:0] nxt_addr;
  logic [BYTE_W-1:0] nxt_data;

  wgc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  wgc_step #(
    .NUM_PAIRS (NUM_PAIRS),
    .PAIR_W    (PAIR_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_step (
    .pair_i     (pair_q),
    .bin_i      (bin_q),
    .at_limit_o (at_limit),
    .nxt_pair_o (nxt_pair),
    .nxt_bin_o  (nxt_bin),
    .addr_o     (nxt_addr),
    .data_o     (nxt_data)
  );

  wgc_gray_decode u_dec (
    .stored_i (restore_word),
    .bin_o    (rest_bin)
  );

  assign inc_eff = inc && !worn_q;
  assign fire    = (inc_eff || pending) && !req_q && !pwr_warn && !restore_en && !worn_q;

  wgc_req_track u_req (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .inc_i      (inc_eff),
    .fire_i     (fire),
    .clear_i    (restore_en),
    .worn_i     (worn_q),
    .pending_o  (pending),
    .overflow_o (overflow)
  );

  assign rest_pair = (restore_pair > LAST_PAIR) ? LAST_PAIR : restore_pair;

  always_comb begin
    pair_d = pair_q;
    bin_d  = bin_q;
    worn_d = worn_q;
    req_d  = req_q;
    addr_d = addr_q;
    data_d = data_q;
    if (req_q && wr_ack) req_d = 1'b0;
    if (restore_en) begin
      pair_d = rest_pair;
      bin_d  = rest_bin;
      worn_d = 1'b0;
    end else if (fire) begin
      if (at_limit) begin
        worn_d = 1'b1;
      end else begin
        pair_d = nxt_pair;
        bin_d  = nxt_bin;
        req_d  = 1'b1;
        addr_d = nxt_addr;
        data_d = nxt_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pair_q <= '0;
      bin_q  <= '0;
      worn_q <= 1'b0;
      req_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      pair_q <= pair_d;
      bin_q  <= bin_d;
      worn_q <= worn_d;
      req_q  <= req_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign wr_req    = req_q;
  assign wr_addr   = addr_q;
  assign wr_data   = data_q;
  assign count_out = {pair_q, bin_q};
  assign worn_out  = worn_q;
endmodule

// File: rtl/wgc_checker.sv
module wgc_checker #(
  parameter int NUM_PAIRS = 153,
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 0,
  parameter int CNT_W     = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_warn,
  input logic              restore_en,
  input logic              wr_req,
  input logic              wr_ack,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic [CNT_W-1:0]  count_out,
  input logic              overflow,
  input logic              worn_out
);
  // R7: request, address and data held until acknowledged
  assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));

  // R7: request released after acknowledge
  assert_drop_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_ack |=> !wr_req);

  // R6: no write begins under power warning
  assert_no_start_in_warn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req && pwr_warn |=> !wr_req);

  // R5: every new write advances the total count by one
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req) |-> count_out == $past(count_out) + CNT_W'(1));

  // R8: overflow stays set until a restore
  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !restore_en |=> overflow);

  // R10: a worn-out counter starts no write
  assert_worn_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    worn_out && !wr_req |=> !wr_req);

  // R2: writes stay inside the pair region
  assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (int'(wr_addr) >= BASE_ADDR) && (int'(wr_addr) < BASE_ADDR + 2 * NUM_PAIRS));
endmodule

bind wear_gray_counter wgc_checker #(
  .NUM_PAIRS (NUM_PAIRS),
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR),
  .CNT_W     (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_warn   (pwr_warn),
  .restore_en (restore_en),
  .wr_req     (wr_req),
  .wr_ack     (wr_ack),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .count_out  (count_out),
  .overflow   (overflow),
  .worn_out   (worn_out)
);

// File: tb/wear_gray_counter_test.sv
`timescale 1ns/1ps
module wear_gray_counter_test;
  localparam int NP = 153;
  localparam int PW = 8;
  localparam int CW = 24;

  typedef struct packed {
    logic [7:0]  pair;
    logic [15:0] word;
    logic [23:0] cnt;
    logic [15:0] addr;
    logic [7:0]  data;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{8'd0, 16'h0000, 24'd0,      16'd1,  8'h80},
    '{8'd0, 16'h8000, 24'd1,      16'd0,  8'h01},
    '{8'd2, 16'h0001, 24'd131075, 16'd4,  8'h03},
    '{8'd5, 16'h4000, 24'd393215, 16'd13, 8'h00},
    '{8'd1, 16'hC000, 24'd131070, 16'd3,  8'h40},
    '{8'd0, 16'h0020, 24'd127,    16'd0,  8'h60},
    '{8'd0, 16'h0100, 24'd1023,   16'd1,  8'h03}
  };

  logic clk = 1'b0;
  logic rst_n, inc, pwr_warn, restore_en;
  logic [PW-1:0] restore_pair;
  logic [15:0] restore_word;
  logic wr_req, wr_ack, overflow, worn_out;
  logic [15:0] wr_addr;
  logic [7:0] wr_data;
  logic [CW-1:0] count_out;
  logic ack_auto, ack_man;

  int checks = 0;
  int fails  = 0;

  assign wr_ack = ack_auto ? wr_req : ack_man;

  always #2.5 clk = ~clk;

  wear_gray_counter #(.NUM_PAIRS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .inc(inc), .pwr_warn(pwr_warn),
    .restore_en(restore_en), .restore_pair(restore_pair), .restore_word(restore_word),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .count_out(count_out), .overflow(overflow), .worn_out(worn_out)
  );

  function automatic logic [15:0] stw(input logic [15:0] b);
    logic [15:0] g;
    g = b ^ {1'b0, b[15:1]};
    return {g[0], g[15:1]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // full-pass monitor with independent model
  logic mon_en = 1'b0;
  logic prev_req = 1'b0;
  int mdl = 0, n_lo = 0, n_hi = 0, n_bad = 0;
  always @(negedge clk) begin
    if (mon_en && wr_req && !prev_req) begin
      logic [15:0] ow, nw;
      logic hi;
      ow = stw(mdl[15:0]);
      mdl = mdl + 1;
      nw = stw(mdl[15:0]);
      hi = (ow[15:8] != nw[15:8]);
      if (wr_addr[0]) n_hi++; else n_lo++;
      if (wr_addr != 16'(2 * (mdl >> 16) + int'(hi)) ||
          wr_data != (hi ? nw[15:8] : nw[7:0])) n_bad++;
    end
    prev_req = wr_req;
  end

  task automatic do_restore(input logic [7:0] p, input logic [15:0] w);
    @(negedge clk);
    restore_en = 1'b1; restore_pair = p; restore_word = w;
    @(negedge clk);
    restore_en = 1'b0;
  endtask

  task automatic pulse_inc();
    @(negedge clk); inc = 1'b1;
    @(negedge clk); inc = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; inc = 1'b0; pwr_warn = 1'b0; restore_en = 1'b0;
    restore_pair = '0; restore_word = '0; ack_auto = 1'b1; ack_man = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(wr_req == 1'b0, "R11 wr_req", int'(wr_req), 0);
    chk(count_out == 0, "R11 count_out", int'(count_out), 0);
    chk(overflow == 1'b0, "R11 overflow", int'(overflow), 0);
    chk(worn_out == 1'b0, "R11 worn_out", int'(worn_out), 0);

    // vector table: R9 restore decode, R1/R2 write byte, R4 rollover, R5 count
    foreach (VECS[i]) begin
      do_restore(VECS[i].pair, VECS[i].word);
      chk(count_out == VECS[i].cnt, "R9 restore count", int'(count_out), int'(VECS[i].cnt));
      pulse_inc();
      chk(wr_req == 1'b1, "R2 write issued", int'(wr_req), 1);
      chk(wr_addr == VECS[i].addr, "R2 R4 address", int'(wr_addr), int'(VECS[i].addr));
      chk(wr_data == VECS[i].data, "R1 R4 data", int'(wr_data), int'(VECS[i].data));
      chk(count_out == VECS[i].cnt + 1, "R5 count step", int'(count_out), int'(VECS[i].cnt) + 1);
      @(negedge clk);
      chk(wr_req == 1'b0, "R7 release", int'(wr_req), 0);
    end

    // R6 power warning blocks a start, increment kept pending
    do_restore(8'd0, 16'h0000);
    ack_auto = 1'b0;
    pwr_warn = 1'b1;
    pulse_inc();
    repeat (3) @(negedge clk);
    chk(wr_req == 1'b0, "R6 no start", int'(wr_req), 0);
    chk(count_out == 0, "R6 count held", int'(count_out), 0);
    pwr_warn = 1'b0;
    @(negedge clk);
    chk(wr_req == 1'b1 && count_out == 1, "R6 pending start", int'(count_out), 1);
    pwr_warn = 1'b1;
    repeat (2) @(negedge clk);
    chk(wr_req == 1'b1 && wr_addr == 16'd1, "R7 held in warn", int'(wr_req), 1);
    ack_man = 1'b1;
    @(negedge clk);
    ack_man = 1'b0;
    chk(wr_req == 1'b0, "R6 in-flight completes", int'(wr_req), 0);
    pwr_warn = 1'b0;

    // R8 pending and overflow
    do_restore(8'd0, 16'h0000);
    @(negedge clk); inc = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); inc = 1'b0;
    chk(overflow == 1'b1, "R8 overflow set", int'(overflow), 1);
    chk(count_out == 1, "R8 one started", int'(count_out), 1);
    ack_man = 1'b1;
    @(negedge clk); ack_man = 1'b0;
    @(negedge clk);
    chk(wr_req == 1'b1 && count_out == 2, "R8 held increment issued", int'(count_out), 2);
    chk(wr_addr == 16'd0 && wr_data == 8'h01, "R8 held write data", int'(wr_data), 1);
    ack_man = 1'b1;
    @(negedge clk); ack_man = 1'b0;
    repeat (2) @(negedge clk);
    chk(overflow == 1'b1 && count_out == 2, "R8 sticky no extra", int'(count_out), 2);
    ack_auto = 1'b1;

    // R10 worn out
    do_restore(8'd152, 16'hC000);
    chk(overflow == 1'b0, "R9 overflow cleared", int'(overflow), 0);
    pulse_inc();
    chk(wr_req && wr_addr == 16'd305 && wr_data == 8'h40, "R10 last write", int'(wr_addr), 305);
    @(negedge clk);
    pulse_inc();
    chk(wr_req == 1'b0 && worn_out == 1'b1, "R10 worn set", int'(worn_out), 1);
    pulse_inc();
    chk(wr_req == 1'b0, "R10 no write", int'(wr_req), 0);
    chk(count_out == 24'd10027007, "R10 count held", int'(count_out), 10027007);
    do_restore(8'd0, 16'h0000);
    chk(worn_out == 1'b0, "R9 worn cleared", int'(worn_out), 0);

    // R3 full pass wear totals
    mdl = 0;
    mon_en = 1'b1;
    for (int k = 0; k < 65536; k++) begin
      @(negedge clk); inc = 1'b1;
      @(negedge clk); inc = 1'b0;
    end
    repeat (3) @(negedge clk);
    mon_en = 1'b0;
    chk(n_lo == 32640, "R3 low byte writes", n_lo, 32640);
    chk(n_hi == 32896, "R3 high byte writes", n_hi, 32896);
    chk(n_bad == 0, "R1 R2 pass writes", n_bad, 0);
    chk(count_out == 65536, "R4 R5 pass count", int'(count_out), 65536);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule